// File: doc/BRIEF.md
# Clock Loss Supervisor with Mode Fallback

This block supervises the two clocks of a clock generator: an external reference clock and the oscillator clock of a frequency-locked loop. It samples each clock with its own local clock and declares the clock lost when no level change has been seen for a set number of cycles. When a lost clock is one the active mode depends on, the block moves the generator to a safe mode by itself. The fallback target depends on the mode that was active.

Software selects one of four modes by writing a control strobe. The block reports the active mode in a status field, and it keeps two sticky flags: one for loss of clock and one for loss of lock. The enables that software writes turn these flags into an interrupt or a reset request. A lock bit follows the loop's lock indication. Software-caused disturbances such as a new multiplier, a new mode or a trim step in the internal-reference mode are treated as expected. They drop the lock bit until the loop locks again, and they do not raise the loss-of-lock flag.

Top module: `clk_sup`

## Requirements
- R1: A monitored clock counts as lost once LIMIT (default 64) local cycles pass with no level change seen on it through a two-stage synchronizer. A clock that changes level every 5 local cycles is never reported as lost.
- R2: In mode 11 (FLL engaged, external reference), losing the reference clock sets both the mode-select field and the status field to 00 (self-clocked).
- R3: In mode 11, losing the oscillator clock while the reference clock is still present sets both fields to 10 (FLL bypassed, external reference).
- R4: In mode 10, losing the reference clock sets both fields to 00. The loss-of-lock flag is not set, because the loop is not engaged in mode 10.
- R5: Mode encoding is 00 self-clocked, 01 FLL engaged internal, 10 FLL bypassed external, 11 FLL engaged external. A control write updates the select field at the next edge, and the status field takes that value one cycle later.
- R6: The loss-of-clock flag is sticky. It clears only when a status read is later followed by a clear-flag write, and that write clears both flags. A clear-flag write that has no read before it has no effect. A loss that persists keeps the flag set even when a clear arrives.
- R7: With the clock-loss reset enable at 1, a set loss-of-clock flag drives rst_req_o. With that enable at 0, the flag drives irq_o. irq_o and rst_req_o are never both high.
- R8: With the lock-loss reset enable at 1, the clock-loss reset enable at 0 and both flags set, rst_req_o is 1 and irq_o is 0.
- R9: A loss of a monitored clock while in mode 01 or 11 also sets the loss-of-lock flag. In mode 01 no mode change follows.
- R10: A write that changes the mode or the multiplier, or a trim strobe while in mode 01, clears lock_o until the next rising edge of lock_i. A fall of lock_i during that window does not set the loss-of-lock flag. A trim strobe in mode 11 leaves lock_o unchanged.
- R11: A fall of lock_i in mode 01 or 11 outside an expected window sets the loss-of-lock flag.
- R12: The oscillator clock is not monitored in mode 10. In mode 00 it is monitored only while osc_stable_i is 1.
- R13: When a control write and an automatic fallback happen at the same edge, the fallback wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock being watched |
| osc_clk_i | input | 1 | Loop oscillator clock being watched |
| osc_stable_i | input | 1 | Oscillator reported stable; enables oscillator watch in mode 00 |
| lock_i | input | 1 | Lock indication from the loop |
| wr_ctrl_i | input | 1 | Control write strobe |
| mode_i | input | 2 | Mode to select on a control write |
| mult_i | input | MW | Multiplier value on a control write |
| clk_rst_en_i | input | 1 | Clock-loss reset enable on a control write |
| lock_rst_en_i | input | 1 | Lock-loss reset enable on a control write |
| trim_wr_i | input | 1 | Trim write strobe |
| rd_stat_i | input | 1 | Status read strobe (arms the flag clear) |
| wr_clr_i | input | 1 | Clear-flag write strobe |
| mode_sel_o | output | 2 | Mode-select field |
| mode_stat_o | output | 2 | Current-mode status field |
| mult_o | output | MW | Stored multiplier |
| lock_o | output | 1 | Lock bit |
| clk_loss_o | output | 1 | Sticky loss-of-clock flag |
| lock_loss_o | output | 1 | Sticky loss-of-lock flag |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request |

## Verification
Two pairs of events can fall on the same edge. The first is a software mode write and an automatic fallback. The bench stops the reference clock in mode 11 and repeats the mode-11 write on every cycle until the select field moves. It then requires 00 in both fields at that exact cycle. The second pair is a flag clear and a loss that is still present. The bench arms the clear by a read and issues the clear while an unmonitored-then-monitored oscillator loss is active, and it requires the flag to stay set.

// File: rtl/clk_sup_pkg.sv
`timescale 1ns/1ps
package clk_sup_pkg;
  typedef enum logic [1:0] {
    MODE_SELF    = 2'b00,
    MODE_FLL_INT = 2'b01,
    MODE_BYP_EXT = 2'b10,
    MODE_FLL_EXT = 2'b11
  } mode_e;

  function automatic logic loop_engaged(mode_e m);
    return (m == MODE_FLL_INT) || (m == MODE_FLL_EXT);
  endfunction
endpackage

// File: rtl/clk_sup_watch.sv
`timescale 1ns/1ps
module clk_sup_watch #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk_i,
  output logic lost_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          s1_q, s2_q, s3_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          edge_seen;
  logic          cnt_en;

  always_comb begin
    edge_seen = s2_q ^ s3_q;
    cnt_en    = edge_seen || (cnt_q != CW'(LIMIT));
    cnt_d     = edge_seen ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= mon_clk_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign lost_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/clk_sup_mode.sv
`timescale 1ns/1ps
module clk_sup_mode
  import clk_sup_pkg::*;
#(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl_i,
  input  logic [1:0]    mode_i,
  input  logic [MW-1:0] mult_i,
  input  logic          ref_ev_i,
  input  logic          osc_ev_i,
  output mode_e         sel_o,
  output mode_e         stat_o,
  output logic [MW-1:0] mult_o,
  output logic          fall_o,
  output logic          wr_ok_o,
  output logic          chg_o
);
  mode_e         sel_q, sel_d, stat_q, stat_d, fb_mode;
  logic [MW-1:0] mult_q, mult_d;
  logic          fall, wr_ok;

  always_comb begin
    fall    = 1'b0;
    fb_mode = sel_q;
    case (sel_q)
      MODE_FLL_EXT: begin
        if (ref_ev_i) begin
          fall    = 1'b1;
          fb_mode = MODE_SELF;
        end else if (osc_ev_i) begin
          fall    = 1'b1;
          fb_mode = MODE_BYP_EXT;
        end
      end
      MODE_BYP_EXT: begin
        if (ref_ev_i) begin
          fall    = 1'b1;
          fb_mode = MODE_SELF;
        end
      end
      default: ;
    endcase
    wr_ok  = wr_ctrl_i && !fall;
    sel_d  = fall ? fb_mode : (wr_ok ? mode_e'(mode_i) : sel_q);
    stat_d = fall ? fb_mode : sel_q;
    mult_d = mult_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= MODE_SELF;
      stat_q <= MODE_SELF;
      mult_q <= '0;
    end else begin
      sel_q  <= sel_d;
      stat_q <= stat_d;
      if (wr_ok) mult_q <= mult_d;
    end
  end

  assign sel_o   = sel_q;
  assign stat_o  = stat_q;
  assign mult_o  = mult_q;
  assign fall_o  = fall;
  assign wr_ok_o = wr_ok;
  assign chg_o   = wr_ok && ((mode_i != sel_q) || (mult_i != mult_q));
endmodule

// File: rtl/clk_sup_flags.sv
`timescale 1ns/1ps
module clk_sup_flags
  import clk_sup_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e sel_i,
  input  logic  lock_i,
  input  logic  trim_wr_i,
  input  logic  chg_i,
  input  logic  wr_ok_i,
  input  logic  clk_rst_en_i,
  input  logic  lock_rst_en_i,
  input  logic  clk_ev_i,
  input  logic  rd_stat_i,
  input  logic  wr_clr_i,
  output logic  lock_o,
  output logic  clk_loss_o,
  output logic  lock_loss_o,
  output logic  irq_o,
  output logic  rst_req_o
);
  logic engaged, exp_ev, lk_rise, lk_fall, clr;
  logic pend_q, pend_d, lock_q, lock_d, prev_q;
  logic arm_q, arm_d, cl_q, cl_d, ll_q, ll_d;
  logic ce_q, le_q;

  always_comb begin
    engaged = loop_engaged(sel_i);
    exp_ev  = chg_i || (trim_wr_i && (sel_i == MODE_FLL_INT));
    lk_rise = lock_i && !prev_q;
    lk_fall = !lock_i && prev_q;
    pend_d  = exp_ev ? 1'b1 : (lk_rise ? 1'b0 : pend_q);
    lock_d  = engaged && lock_i && !pend_d && !clk_ev_i;
    clr     = wr_clr_i && arm_q;
    arm_d   = rd_stat_i ? 1'b1 : (clr ? 1'b0 : arm_q);
    cl_d    = clk_ev_i || (cl_q && !clr);
    ll_d    = (engaged && (clk_ev_i || (lk_fall && !pend_q))) || (ll_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lock_q <= 1'b0;
      prev_q <= 1'b0;
      arm_q  <= 1'b0;
      cl_q   <= 1'b0;
      ll_q   <= 1'b0;
      ce_q   <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lock_q <= lock_d;
      prev_q <= lock_i;
      arm_q  <= arm_d;
      cl_q   <= cl_d;
      ll_q   <= ll_d;
      if (wr_ok_i) begin
        ce_q <= clk_rst_en_i;
        le_q <= lock_rst_en_i;
      end
    end
  end

  assign lock_o      = lock_q;
  assign clk_loss_o  = cl_q;
  assign lock_loss_o = ll_q;
  assign rst_req_o   = (cl_q && ce_q) || (ll_q && le_q);
  assign irq_o       = !rst_req_o && ((cl_q && !ce_q) || (ll_q && !le_q));
endmodule

// File: rtl/clk_sup.sv
`timescale 1ns/1ps
module clk_sup
  import clk_sup_pkg::*;
#(
  parameter int LIMIT = 64,
  parameter int MW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_clk_i,
  input  logic          osc_clk_i,
  input  logic          osc_stable_i,
  input  logic          lock_i,
  input  logic          wr_ctrl_i,
  input  logic [1:0]    mode_i,
  input  logic [MW-1:0] mult_i,
  input  logic          clk_rst_en_i,
  input  logic          lock_rst_en_i,
  input  logic          trim_wr_i,
  input  logic          rd_stat_i,
  input  logic          wr_clr_i,
  output logic [1:0]    mode_sel_o,
  output logic [1:0]    mode_stat_o,
  output logic [MW-1:0] mult_o,
  output logic          lock_o,
  output logic          clk_loss_o,
  output logic          lock_loss_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  localparam int NCLK = 2;

  logic [NCLK-1:0] mon_clk, lost;
  mode_e           sel, stat;
  logic            ref_mon, osc_mon, ref_ev, osc_ev, clk_ev;
  logic            fall, wr_ok, chg;

  assign mon_clk = {osc_clk_i, ref_clk_i};

  for (genvar i = 0; i < NCLK; i++) begin : g_watch
    clk_sup_watch #(.LIMIT(LIMIT)) u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .mon_clk_i (mon_clk[i]),
      .lost_o    (lost[i])
    );
  end

  always_comb begin
    ref_mon = (sel == MODE_BYP_EXT) || (sel == MODE_FLL_EXT);
    osc_mon = loop_engaged(sel) || ((sel == MODE_SELF) && osc_stable_i);
    ref_ev  = lost[0] && ref_mon;
    osc_ev  = lost[1] && osc_mon;
    clk_ev  = ref_ev || osc_ev;
  end

  clk_sup_mode #(.MW(MW)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr_ctrl_i),
    .mode_i    (mode_i),
    .mult_i    (mult_i),
    .ref_ev_i  (ref_ev),
    .osc_ev_i  (osc_ev),
    .sel_o     (sel),
    .stat_o    (stat),
    .mult_o    (mult_o),
    .fall_o    (fall),
    .wr_ok_o   (wr_ok),
    .chg_o     (chg)
  );

  clk_sup_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_i         (sel),
    .lock_i        (lock_i),
    .trim_wr_i     (trim_wr_i),
    .chg_i         (chg),
    .wr_ok_i       (wr_ok),
    .clk_rst_en_i  (clk_rst_en_i),
    .lock_rst_en_i (lock_rst_en_i),
    .clk_ev_i      (clk_ev),
    .rd_stat_i     (rd_stat_i),
    .wr_clr_i      (wr_clr_i),
    .lock_o        (lock_o),
    .clk_loss_o    (clk_loss_o),
    .lock_loss_o   (lock_loss_o),
    .irq_o         (irq_o),
    .rst_req_o     (rst_req_o)
  );

  assign mode_sel_o  = sel;
  assign mode_stat_o = stat;
endmodule

// File: rtl/clk_sup_chk.sv
`timescale 1ns/1ps
module clk_sup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sel,
  input logic [1:0] stat,
  input logic       ref_ev,
  input logic       osc_ev,
  input logic       clk_ev,
  input logic       fall,
  input logic       wr_ok,
  input logic       chg,
  input logic       wr_ctrl_i,
  input logic       wr_clr_i,
  input logic       lock_o,
  input logic       clk_loss_o,
  input logic       irq_o,
  input logic       rst_req_o
);
  assert_flag_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_loss_o) |-> $past(clk_ev));

  assert_ext_ref_fallback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11 && ref_ev) |=> (sel == 2'b00 && stat == 2'b00));

  assert_ext_osc_fallback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11 && !ref_ev && osc_ev) |=> (sel == 2'b10 && stat == 2'b10));

  assert_byp_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10 && ref_ev) |=> (sel == 2'b00));

  assert_stat_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> (stat == $past(sel)));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_loss_o) |-> $past(wr_clr_i));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_req_o));

  assert_expected_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && chg) |=> !lock_o);

  assert_fall_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i && fall) |=> (sel == stat));
endmodule

bind clk_sup clk_sup_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .stat       (stat),
  .ref_ev     (ref_ev),
  .osc_ev     (osc_ev),
  .clk_ev     (clk_ev),
  .fall       (fall),
  .wr_ok      (wr_ok),
  .chg        (chg),
  .wr_ctrl_i  (wr_ctrl_i),
  .wr_clr_i   (wr_clr_i),
  .lock_o     (lock_o),
  .clk_loss_o (clk_loss_o),
  .irq_o      (irq_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/sim_clk_sup.sv
`timescale 1ns/1ps
module sim_clk_sup;
  logic       clk, rst_n;
  logic       ref_clk, osc_clk, osc_stable, lock_in;
  logic       wr_ctrl, ce_in, le_in, trim_wr, rd_stat, wr_clr;
  logic [1:0] mode_in;
  logic [2:0] mult_in;
  logic [1:0] sel_o, stat_o;
  logic [2:0] mult_o;
  logic       lock_o, cl_o, ll_o, irq_o, rst_o;
  logic       ref_run, osc_run;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  clk_sup u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .osc_clk_i(osc_clk),
    .osc_stable_i(osc_stable), .lock_i(lock_in), .wr_ctrl_i(wr_ctrl),
    .mode_i(mode_in), .mult_i(mult_in), .clk_rst_en_i(ce_in),
    .lock_rst_en_i(le_in), .trim_wr_i(trim_wr), .rd_stat_i(rd_stat),
    .wr_clr_i(wr_clr), .mode_sel_o(sel_o), .mode_stat_o(stat_o),
    .mult_o(mult_o), .lock_o(lock_o), .clk_loss_o(cl_o),
    .lock_loss_o(ll_o), .irq_o(irq_o), .rst_req_o(rst_o)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    ref_clk = 1'b0;
    forever begin
      repeat (5) @(negedge clk);
      if (ref_run) ref_clk = ~ref_clk;
    end
  end

  initial begin
    osc_clk = 1'b0;
    forever begin
      repeat (5) @(negedge clk);
      if (osc_run) osc_clk = ~osc_clk;
    end
  end

  function automatic logic exp_rst(logic cl, logic ll, logic ce, logic le);
    return (cl && ce) || (ll && le);
  endfunction

  function automatic logic exp_irq(logic cl, logic ll, logic ce, logic le);
    return !exp_rst(cl, ll, ce, le) && ((cl && !ce) || (ll && !le));
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] m, input logic [2:0] mu, input logic ce, input logic le);
    wr_ctrl = 1'b1; mode_in = m; mult_in = mu; ce_in = ce; le_in = le;
    @(negedge clk);
    wr_ctrl = 1'b0;
  endtask

  task automatic relock();
    lock_in = 1'b0; step(2);
    lock_in = 1'b1; step(2);
  endtask

  task automatic clear_flags();
    rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0;
    step(1);
    wr_clr = 1'b1; @(negedge clk); wr_clr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic found;
    void'($urandom(32'd7331));
    rst_n = 1'b0; ref_run = 1'b1; osc_run = 1'b1; osc_stable = 1'b0; lock_in = 1'b1;
    wr_ctrl = 1'b0; mode_in = 2'b00; mult_in = 3'd0; ce_in = 1'b0; le_in = 1'b0;
    trim_wr = 1'b0; rd_stat = 1'b0; wr_clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(sel_o == 2'b00 && stat_o == 2'b00, "reset mode R5", sel_o, 0);
    chk(!cl_o && !ll_o && !irq_o && !rst_o && !lock_o, "reset flags R6", {cl_o, ll_o, irq_o, rst_o}, 0);

    // R5: select then status one cycle later
    wr(2'b11, 3'd3, 1'b0, 1'b0);
    chk(sel_o == 2'b11 && stat_o == 2'b00, "R5 select first", {sel_o, stat_o}, 4'b1100);
    step(1);
    chk(stat_o == 2'b11, "R5 status follows", stat_o, 3);
    step(2);
    chk(!lock_o, "R10 lock dropped after mode change", lock_o, 0);
    relock();
    chk(lock_o && !ll_o, "R10 relock, no flag on expected fall", {lock_o, ll_o}, 2);
    trim_wr = 1'b1; @(negedge clk); trim_wr = 1'b0;
    step(1);
    chk(lock_o, "R10 trim in mode 11 keeps lock", lock_o, 1);

    // R1/R2: reference lost in mode 11
    step(20);
    chk(!cl_o && sel_o == 2'b11, "R1 running clocks not lost", cl_o, 0);
    ref_run = 1'b0;
    step(40);
    chk(!cl_o && sel_o == 2'b11, "R1 not lost before limit", sel_o, 3);
    step(60);
    chk(sel_o == 2'b00 && stat_o == 2'b00, "R2 fallback to self", {sel_o, stat_o}, 0);
    chk(cl_o && ll_o, "R9 clock loss sets both flags", {cl_o, ll_o}, 3);
    chk(irq_o && !rst_o, "R7 interrupt when reset disabled", {irq_o, rst_o}, 2);
    ref_run = 1'b1;
    step(20);

    // R6: clear sequencing
    wr_clr = 1'b1; @(negedge clk); wr_clr = 1'b0;
    step(1);
    chk(cl_o, "R6 clear without read ignored", cl_o, 1);
    clear_flags();
    chk(!cl_o && !ll_o && !irq_o, "R6 read then clear", {cl_o, ll_o}, 0);

    // R3: oscillator lost in mode 11
    wr(2'b11, 3'd3, 1'b0, 1'b0);
    relock();
    osc_run = 1'b0;
    step(100);
    chk(sel_o == 2'b10 && stat_o == 2'b10, "R3 fallback to bypass", {sel_o, stat_o}, 4'b1010);
    chk(cl_o && ll_o, "R9 osc loss in mode 11", {cl_o, ll_o}, 3);
    osc_run = 1'b1;
    step(20);
    clear_flags();

    // R12 / R4 in bypass mode
    osc_run = 1'b0;
    step(100);
    chk(!cl_o && sel_o == 2'b10, "R12 osc ignored in bypass", cl_o, 0);
    osc_run = 1'b1;
    step(20);
    ref_run = 1'b0;
    step(100);
    chk(sel_o == 2'b00 && stat_o == 2'b00, "R4 bypass falls to self", sel_o, 0);
    chk(cl_o && !ll_o, "R4 no lock flag in bypass", {cl_o, ll_o}, 2);
    ref_run = 1'b1;
    step(20);
    clear_flags();

    // R12 self-clocked with stable gating, R6 set beats clear
    osc_run = 1'b0;
    step(100);
    chk(!cl_o, "R12 osc not watched without stable", cl_o, 0);
    osc_stable = 1'b1;
    step(5);
    chk(cl_o, "R12 osc watched once stable", cl_o, 1);
    clear_flags();
    step(1);
    chk(cl_o, "R6 persisting loss beats clear", cl_o, 1);
    osc_stable = 1'b0;
    osc_run = 1'b1;
    step(20);
    clear_flags();
    chk(!cl_o, "R6 clear after loss ends", cl_o, 0);

    // R9/R7/R8 in mode 01
    wr(2'b01, 3'd2, 1'b1, 1'b0);
    relock();
    osc_run = 1'b0;
    step(100);
    chk(sel_o == 2'b01 && cl_o && ll_o, "R9 no fallback in mode 01", {sel_o, cl_o, ll_o}, 7);
    wr(2'b01, 3'd2, 1'b0, 1'b1);
    step(1);
    chk(rst_o && !irq_o, "R8 lock reset overrides interrupt", {rst_o, irq_o}, 2);
    wr(2'b01, 3'd2, 1'b1, 1'b0);
    step(1);
    chk(rst_o && !irq_o, "R7 clock loss reset", {rst_o, irq_o}, 2);
    wr(2'b01, 3'd2, 1'b0, 1'b0);
    step(1);
    chk(irq_o && !rst_o, "R7 interrupt only", {rst_o, irq_o}, 1);
    osc_run = 1'b1;
    step(20);
    clear_flags();
    step(2);
    chk(lock_o && !ll_o, "R11 lock back before fall", {lock_o, ll_o}, 2);
    lock_in = 1'b0;
    step(3);
    chk(ll_o && !lock_o, "R11 unexpected fall flagged", {ll_o, lock_o}, 2);
    lock_in = 1'b1;
    step(3);
    clear_flags();
    trim_wr = 1'b1; @(negedge clk); trim_wr = 1'b0;
    step(1);
    chk(!lock_o, "R10 trim in mode 01 drops lock", lock_o, 0);
    relock();
    chk(lock_o && !ll_o, "R10 trim relock no flag", {lock_o, ll_o}, 2);

    // R13: write coinciding with fallback
    wr(2'b11, 3'd2, 1'b0, 1'b0);
    relock();
    ref_run = 1'b0;
    found = 1'b0;
    for (int i = 0; i < 300 && !found; i++) begin
      wr_ctrl = 1'b1; mode_in = 2'b11; mult_in = 3'd2;
      @(negedge clk);
      if (sel_o == 2'b00) found = 1'b1;
    end
    wr_ctrl = 1'b0;
    chk(found && stat_o == 2'b00, "R13 fallback beats write", {found, stat_o}, 4);
    ref_run = 1'b1;
    step(20);

    // R5/R7 random writes; flags both set here
    for (int k = 0; k < 24; k++) begin
      logic [1:0] m;
      logic [2:0] mu;
      logic ce, le;
      m = 2'($urandom_range(3)); mu = 3'($urandom_range(7));
      ce = 1'($urandom_range(1)); le = 1'($urandom_range(1));
      wr(m, mu, ce, le);
      chk(sel_o == m && mult_o == mu, "R5 random select", sel_o, m);
      step(1);
      chk(stat_o == m, "R5 random status", stat_o, m);
      chk(rst_o == exp_rst(cl_o, ll_o, ce, le), "R7 random reset", rst_o, exp_rst(cl_o, ll_o, ce, le));
      chk(irq_o == exp_irq(cl_o, ll_o, ce, le), "R8 random interrupt", irq_o, exp_irq(cl_o, ll_o, ce, le));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule